// File: doc/BRIEF.md
# Hearing-Aid Power Mode Controller

This block decides which of three operating modes a rechargeable hearing instrument is in: a low-power sleep mode, a wearing mode in which the signal processor is supplied, and a charging mode entered while the device sits in its charger. It takes a charger-present flag, a push-button line and a sleep request from the host processor. It also takes digital flags from battery voltage comparators, a chemistry select and two configuration fields from one-time-programmable storage. From these it drives the enable of the processor supply, a shutdown warning, a button copy for the host and a flag that records whether the battery is still healthy.

Both pins that can change the mode are filtered by time. The button must be held for a qualification window while the battery sits in the window valid for its chemistry. The host's sleep request must be held for a minimum number of cycles. When the charger is connected while the device is worn, the warning rises at once. The supply stays on for a programmed number of half-second ticks, which gives the host time to shut down cleanly before power is cut.

All windows are given in clock cycles through parameters. The default values assume a clock of about 32 kHz.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset the block is in sleep mode with `loadEn`, `warnOut` and `btnOut` low and `safeMode` high.
- R2: While `cradleConn` is high the block enters charging mode from any mode at the next clock edge. `warnOut` is high exactly while the block is in charging mode.
- R3: When charging mode is entered from wearing mode, `loadEn` stays high for `warnCode` × `TICK_CYC` cycles after the entry edge and then falls. A `warnCode` of 0 acts as 1.
- R4: `loadEn` only rises on entry to wearing mode. It is low in sleep mode and stays low in charging mode when that mode is entered from sleep.
- R5: When `cradleConn` falls, the block enters wearing mode (`loadEn` high) if `cfgNoButton` is 1 and the battery is valid. Otherwise it enters sleep mode.
- R6: In sleep mode the block wakes to wearing mode once `btnIn` has been high, with the battery valid, for `BTN_QUAL_CYC` consecutive cycles. A shorter press does not wake it, and an invalid battery restarts the count.
- R7: With `chemLi`=0 the battery is valid when `vbatOver1v1`=1 and `vbatUnder2v2`=1. With `chemLi`=1 it is valid when `vbatOver3v0`=1.
- R8: In wearing mode, `sleepReq` held high for `REQ_QUAL_CYC` consecutive cycles moves the block to sleep mode, and shorter pulses have no effect. `sleepReq` is ignored in charging mode.
- R9: In wearing mode, a battery below its safety level moves the block to sleep mode and clears `safeMode`. The battery is below its safety level when `vbatOver2v8`=0 with `chemLi`=1, or when `vbatOver1v0`=0 with `chemLi`=0. `safeMode` is set again on entry to charging mode.
- R10: `btnOut` equals `btnIn` in wearing mode and is 0 in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cradleConn | input | 1 | Charger connected |
| btnIn | input | 1 | Push-button line |
| sleepReq | input | 1 | Sleep request from the host processor |
| chemLi | input | 1 | 1 = lithium-ion, 0 = zinc-air or silver-zinc |
| vbatOver1v1 | input | 1 | Battery above 1.1 V |
| vbatUnder2v2 | input | 1 | Battery below 2.2 V |
| vbatOver3v0 | input | 1 | Battery above 3.0 V |
| vbatOver2v8 | input | 1 | Battery above 2.8 V |
| vbatOver1v0 | input | 1 | Battery above 1.0 V |
| cfgNoButton | input | 1 | Enter wearing mode directly on leaving the charger |
| warnCode | input | 8 | Warning delay in half-second ticks |
| loadEn | output | 1 | Processor supply enable |
| warnOut | output | 1 | Shutdown warning |
| btnOut | output | 1 | Button copy for the host |
| safeMode | output | 1 | Battery still above its safety level |

## Verification
The hardest point to reach from the ports is the exact cycle on which the supply is cut after a warning. Reaching it needs a wake-up through a fully qualified press first, then a charger connection while worn, and the cycle depends on the tick prescaler and the remaining-tick count together. The bench builds the design with short windows and wakes it with an exact press. It then connects the charger on a known edge and samples `loadEn` on the last cycle before the cut and on the first cycle after it, once with a non-zero code and once with code 0. The two filtering windows are probed in the same way, with pulses exactly one cycle shorter than the window and with pulses of exactly the window length.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic [1:0] {
    MODE_SLEEP  = 2'd0,
    MODE_AID    = 2'd1,
    MODE_CRADLE = 2'd2
  } modeT;

  // control -> datapath strobes
  typedef struct packed {
    logic btnArm;
    logic reqArm;
    logic warnStart;
    logic warnRun;
  } ctlStrobesT;

  // datapath -> control status
  typedef struct packed {
    logic btnQual;
    logic reqQual;
    logic warnDone;
    logic battValid;
    logic battLow;
  } dpStatusT;

endpackage

// File: rtl/pmc_dpath.sv
module pmc_dpath
  import pmc_pkg::*;
#(
  parameter int BTN_QUAL_CYC = 656,
  parameter int REQ_QUAL_CYC = 4,
  parameter int TICK_CYC     = 16384,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobesT        strb,
  input  logic              btnIn,
  input  logic              sleepReq,
  input  logic              chemLi,
  input  logic              vbatOver1v1,
  input  logic              vbatUnder2v2,
  input  logic              vbatOver3v0,
  input  logic              vbatOver2v8,
  input  logic              vbatOver1v0,
  input  logic [CODE_W-1:0] warnCode,
  output dpStatusT          stat
);

  localparam int BW = $clog2(BTN_QUAL_CYC + 1);
  localparam int RW = $clog2(REQ_QUAL_CYC + 1);
  localparam int TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam logic [BW-1:0] BTN_LAST  = BW'(BTN_QUAL_CYC - 1);
  localparam logic [RW-1:0] REQ_LAST  = RW'(REQ_QUAL_CYC - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYC - 1);

  logic [BW-1:0]     btnCntQ;
  logic [RW-1:0]     reqCntQ;
  logic [TW-1:0]     preQ;
  logic [CODE_W-1:0] remQ;
  logic              battValid;
  logic              btnCounting;
  logic              reqCounting;
  logic [CODE_W-1:0] codeEff;

  // battery window per chemistry
  assign battValid = chemLi ? vbatOver3v0 : (vbatOver1v1 & vbatUnder2v2);
  assign codeEff   = (warnCode == '0) ? CODE_W'(1) : warnCode;

  assign btnCounting = strb.btnArm & btnIn & battValid;
  assign reqCounting = strb.reqArm & sleepReq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      btnCntQ <= '0;
    end else if (!btnCounting) begin
      btnCntQ <= '0;
    end else if (btnCntQ != BTN_LAST) begin
      btnCntQ <= btnCntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reqCntQ <= '0;
    end else if (!reqCounting) begin
      reqCntQ <= '0;
    end else if (reqCntQ != REQ_LAST) begin
      reqCntQ <= reqCntQ + 1'b1;
    end
  end

  // warning countdown: prescaler of TICK_CYC cycles, then remaining ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preQ <= '0;
      remQ <= '0;
    end else if (strb.warnStart) begin
      preQ <= '0;
      remQ <= codeEff;
    end else if (strb.warnRun) begin
      if (preQ == TICK_LAST) begin
        preQ <= '0;
        remQ <= remQ - 1'b1;
      end else begin
        preQ <= preQ + 1'b1;
      end
    end
  end

  always_comb begin
    stat.battValid = battValid;
    stat.battLow   = chemLi ? ~vbatOver2v8 : ~vbatOver1v0;
    stat.btnQual   = btnCounting & (btnCntQ == BTN_LAST);
    stat.reqQual   = reqCounting & (reqCntQ == REQ_LAST);
    stat.warnDone  = strb.warnRun & (preQ == TICK_LAST) & (remQ == CODE_W'(1));
  end

  // R3
  warn_rem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.warnRun |-> (remQ != '0));

  // R8
  req_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.reqArm |=> (reqCntQ == '0));

endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cradleConn,
  input  logic       btnIn,
  input  logic       cfgNoButton,
  input  dpStatusT   stat,
  output ctlStrobesT strb,
  output logic       loadEn,
  output logic       warnOut,
  output logic       btnOut,
  output logic       safeMode
);

  modeT modeQ, modeD;
  logic loadD, safeD;

  always_comb begin
    modeD = modeQ;
    loadD = loadEn;
    safeD = safeMode;
    unique case (modeQ)
      MODE_SLEEP: begin
        loadD = 1'b0;
        if (cradleConn) begin
          modeD = MODE_CRADLE;
        end else if (stat.btnQual) begin
          modeD = MODE_AID;
          loadD = 1'b1;
        end
      end
      MODE_AID: begin
        if (cradleConn) begin
          modeD = MODE_CRADLE;
        end else if (stat.battLow) begin
          modeD = MODE_SLEEP;
          loadD = 1'b0;
          safeD = 1'b0;
        end else if (stat.reqQual) begin
          modeD = MODE_SLEEP;
          loadD = 1'b0;
        end
      end
      MODE_CRADLE: begin
        if (!cradleConn) begin
          if (cfgNoButton && stat.battValid) begin
            modeD = MODE_AID;
            loadD = 1'b1;
          end else begin
            modeD = MODE_SLEEP;
            loadD = 1'b0;
          end
        end else if (stat.warnDone) begin
          loadD = 1'b0;
        end
      end
      default: begin
        modeD = MODE_SLEEP;
        loadD = 1'b0;
      end
    endcase
    if (modeQ != MODE_CRADLE && modeD == MODE_CRADLE) safeD = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ    <= MODE_SLEEP;
      loadEn   <= 1'b0;
      safeMode <= 1'b1;
    end else begin
      modeQ    <= modeD;
      loadEn   <= loadD;
      safeMode <= safeD;
    end
  end

  always_comb begin
    strb.btnArm    = (modeQ == MODE_SLEEP);
    strb.reqArm    = (modeQ == MODE_AID);
    strb.warnStart = (modeQ != MODE_CRADLE) && cradleConn;
    strb.warnRun   = (modeQ == MODE_CRADLE) && loadEn;
  end

  assign warnOut = (modeQ == MODE_CRADLE);
  assign btnOut  = (modeQ == MODE_AID) & btnIn;

  // R2
  warn_on_cradle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cradleConn |=> warnOut);

  // R4
  load_rise_aid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loadEn) |-> (modeQ == MODE_AID));

  // R4
  sleep_no_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_SLEEP) |-> !loadEn);

  // R8
  req_ignored_cradle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ == MODE_CRADLE && cradleConn) |=> (modeQ == MODE_CRADLE));

  // R9
  safe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(safeMode) |-> (modeQ == MODE_SLEEP && $past(modeQ) == MODE_AID));

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pmc_pkg::*;
#(
  parameter int BTN_QUAL_CYC = 656,
  parameter int REQ_QUAL_CYC = 4,
  parameter int TICK_CYC     = 16384,
  parameter int CODE_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cradleConn,
  input  logic              btnIn,
  input  logic              sleepReq,
  input  logic              chemLi,
  input  logic              vbatOver1v1,
  input  logic              vbatUnder2v2,
  input  logic              vbatOver3v0,
  input  logic              vbatOver2v8,
  input  logic              vbatOver1v0,
  input  logic              cfgNoButton,
  input  logic [CODE_W-1:0] warnCode,
  output logic              loadEn,
  output logic              warnOut,
  output logic              btnOut,
  output logic              safeMode
);

  ctlStrobesT strb;
  dpStatusT   stat;

  pmc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cradleConn  (cradleConn),
    .btnIn       (btnIn),
    .cfgNoButton (cfgNoButton),
    .stat        (stat),
    .strb        (strb),
    .loadEn      (loadEn),
    .warnOut     (warnOut),
    .btnOut      (btnOut),
    .safeMode    (safeMode)
  );

  pmc_dpath #(
    .BTN_QUAL_CYC (BTN_QUAL_CYC),
    .REQ_QUAL_CYC (REQ_QUAL_CYC),
    .TICK_CYC     (TICK_CYC),
    .CODE_W       (CODE_W)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .btnIn        (btnIn),
    .sleepReq     (sleepReq),
    .chemLi       (chemLi),
    .vbatOver1v1  (vbatOver1v1),
    .vbatUnder2v2 (vbatUnder2v2),
    .vbatOver3v0  (vbatOver3v0),
    .vbatOver2v8  (vbatOver2v8),
    .vbatOver1v0  (vbatOver1v0),
    .warnCode     (warnCode),
    .stat         (stat)
  );

endmodule

// File: tb/sim_pwr_mode_ctl.sv
module sim_pwr_mode_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int BTN_Q = 8;
  localparam int REQ_Q = 4;
  localparam int TICK  = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cradleConn = 0, btnIn = 0, sleepReq = 0, chemLi = 1;
  logic vbatOver1v1 = 1, vbatUnder2v2 = 0, vbatOver3v0 = 1, vbatOver2v8 = 1, vbatOver1v0 = 1;
  logic cfgNoButton = 0;
  logic [7:0] warnCode = 8'd3;
  logic loadEn, warnOut, btnOut, safeMode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.BTN_QUAL_CYC(BTN_Q), .REQ_QUAL_CYC(REQ_Q), .TICK_CYC(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .cradleConn(cradleConn), .btnIn(btnIn), .sleepReq(sleepReq),
    .chemLi(chemLi), .vbatOver1v1(vbatOver1v1), .vbatUnder2v2(vbatUnder2v2),
    .vbatOver3v0(vbatOver3v0), .vbatOver2v8(vbatOver2v8), .vbatOver1v0(vbatOver1v0),
    .cfgNoButton(cfgNoButton), .warnCode(warnCode),
    .loadEn(loadEn), .warnOut(warnOut), .btnOut(btnOut), .safeMode(safeMode));

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // advance n rising edges, return at the following falling edge
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic setLiGood();
    chemLi = 1; vbatOver3v0 = 1; vbatOver2v8 = 1; vbatOver1v1 = 1; vbatUnder2v2 = 0; vbatOver1v0 = 1;
  endtask

  task automatic wakeExact();
    btnIn = 1; cyc(BTN_Q); btnIn = 0; cyc(1);
  endtask

  task automatic t_reset();
    chk("R1 loadEn at reset", loadEn, 1'b0);
    chk("R1 warnOut at reset", warnOut, 1'b0);
    chk("R1 btnOut at reset", btnOut, 1'b0);
    chk("R1 safeMode at reset", safeMode, 1'b1);
  endtask

  task automatic t_wake();
    setLiGood();
    btnIn = 1; cyc(BTN_Q - 1);
    chk("R6 short press no wake", loadEn, 1'b0);
    chk("R10 btnOut low in sleep", btnOut, 1'b0);
    btnIn = 0; cyc(3);
    chk("R6 released short press", loadEn, 1'b0);
    btnIn = 1; cyc(BTN_Q - 1);
    chk("R6 one cycle before wake", loadEn, 1'b0);
    cyc(1);
    chk("R6 wake at qualification", loadEn, 1'b1);
    chk("R10 btnOut copies high", btnOut, 1'b1);
    btnIn = 0; #1;
    chk("R10 btnOut copies low", btnOut, 1'b0);
    cyc(1);
  endtask

  task automatic t_sleepReq();
    sleepReq = 1; cyc(REQ_Q - 1); sleepReq = 0; cyc(2);
    chk("R8 short request ignored", loadEn, 1'b1);
    sleepReq = 1; cyc(REQ_Q); sleepReq = 0;
    chk("R8 held request sleeps", loadEn, 1'b0);
    chk("R9 safeMode kept on request", safeMode, 1'b1);
    cyc(1);
  endtask

  task automatic t_window();
    // lithium below 3.0 V
    chemLi = 1; vbatOver3v0 = 0;
    btnIn = 1; cyc(3 * BTN_Q); btnIn = 0; cyc(1);
    chk("R7 li below 3.0 no wake", loadEn, 1'b0);
    // zinc/silver above 2.2 V
    chemLi = 0; vbatOver1v1 = 1; vbatUnder2v2 = 0; vbatOver1v0 = 1;
    btnIn = 1; cyc(3 * BTN_Q); btnIn = 0; cyc(1);
    chk("R7 zinc above 2.2 no wake", loadEn, 1'b0);
    // invalid part-way restarts the count
    vbatUnder2v2 = 1; btnIn = 1; cyc(BTN_Q - 2);
    vbatOver1v1 = 0; cyc(1); vbatOver1v1 = 1; cyc(BTN_Q - 1);
    chk("R6 invalid battery restarts count", loadEn, 1'b0);
    cyc(1);
    chk("R7 zinc in window wakes", loadEn, 1'b1);
    btnIn = 0; cyc(1);
  endtask

  task automatic t_eol();
    // zinc chemistry in wearing mode, drop below 1.0 V
    vbatOver1v0 = 0; cyc(1);
    chk("R9 eol sleeps", loadEn, 1'b0);
    chk("R9 eol clears safeMode", safeMode, 1'b0);
    vbatOver1v0 = 1; setLiGood();
  endtask

  task automatic t_cradleFromSleep();
    cfgNoButton = 0;
    cradleConn = 1; cyc(1);
    chk("R2 warn from sleep", warnOut, 1'b1);
    chk("R9 safeMode set on cradle", safeMode, 1'b1);
    cyc(40);
    chk("R4 no load in cradle from sleep", loadEn, 1'b0);
    cradleConn = 0; cyc(1);
    chk("R5 exit without no-button sleeps", loadEn, 1'b0);
    chk("R2 warn low after exit", warnOut, 1'b0);
  endtask

  task automatic t_cradleDelay(input logic [7:0] code, input int ticks);
    setLiGood();
    wakeExact();
    chk("R6 wake before cradle", loadEn, 1'b1);
    warnCode = code;
    cradleConn = 1; cyc(1);
    chk("R2 warn rises at once", warnOut, 1'b1);
    sleepReq = 1;
    cyc(ticks * TICK - 1);
    chk("R3 load held until last cycle", loadEn, 1'b1);
    chk("R8 request ignored in cradle", warnOut, 1'b1);
    cyc(1);
    chk("R3 load cut after delay", loadEn, 1'b0);
    sleepReq = 0;
    cfgNoButton = 1;
    cradleConn = 0; cyc(1);
    chk("R5 exit with no-button wakes", loadEn, 1'b1);
    chk("R2 warn low in wearing mode", warnOut, 1'b0);
    sleepReq = 1; cyc(REQ_Q); sleepReq = 0; cfgNoButton = 0;
    chk("R8 back to sleep", loadEn, 1'b0);
  endtask

  task automatic t_exitInvalid();
    setLiGood(); wakeExact();
    cfgNoButton = 1; cradleConn = 1; cyc(5);
    vbatOver3v0 = 0; cradleConn = 0; cyc(1);
    chk("R5 exit with bad battery sleeps", loadEn, 1'b0);
    cfgNoButton = 0; setLiGood();
  endtask

  initial begin
    cyc(2);
    t_reset();
    rst_n = 1; cyc(1);
    t_reset();
    t_wake();
    t_sleepReq();
    t_window();
    t_eol();
    t_cradleFromSleep();
    t_cradleDelay(8'd3, 3);
    t_cradleDelay(8'd0, 1);
    t_exitInvalid();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule